// File: doc/BRIEF.md
# Elastic Store Jitter Attenuator

This block removes jitter from a recovered line stream of two-bit symbols. Each symbol is written into a small circular store on the rising edge of the incoming, jittery bit strobe. The symbols are read back out on a clean read strobe. That strobe comes from a single reference clock that runs at eight times the bit rate, so no crystal and no fast PLL are needed.

The read strobe is produced by a divide-by-8 counter. While the store keeps a comfortable fill, the read period is exactly eight reference cycles. When the fill climbs to within two entries of full, one reference cycle is dropped from the period, which speeds the reader up. When the fill falls to within two entries of empty, one cycle is added, which slows it down. The store holds 32 or 64 entries and runs centred on half depth, so a symbol leaves 16 or 32 reads after it entered.

If the fill still hits a hard limit, the store re-centres itself and flags a slip. During loss of signal the read strobe free-runs from the reference at the nominal rate.

Top module: `es_jitter_atten`

## Requirements
- R1: A two-bit symbol is stored on each rising edge of `wr_stb`. Symbols are read out in write order. After reset, with the read pointer half the depth behind, the n-th read returns the symbol of the (n − D/2)-th write, and the first D/2 reads return 2'b00.
- R2: `deep` = 0 selects a 32-entry store with a 16-read latency. `deep` = 1 selects a 64-entry store with a 32-read latency.
- R3: `rd_stb` is a single-cycle pulse and `rd_data` is updated in the same cycle. With the fill neither near full nor near empty, consecutive pulses are exactly 8 reference cycles apart. After reset, `rd_stb`, `rd_data` and `slip` are all 0.
- R4: While the fill is at or above depth − 2, the read period shortens to 7 reference cycles.
- R5: While the fill is at or below 2, the read period lengthens to 9 reference cycles.
- R6: A change of `deep` re-centres the store: the next read comes from half the new depth behind the write pointer.
- R7: A write into a full store without a read (overflow), or a read from an empty store without a write (underflow), re-centres the store and raises `slip` for exactly one cycle.
- R8: While `los` is high, writes are ignored, the read period is fixed at 8 cycles, `rd_data` reads 2'b00 and `slip` stays low.
- R9: When `los` falls, the read divider restarts and the store re-centres. Symbols written afterwards come out D/2 reads later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Incoming bit strobe; a rising edge writes a symbol |
| wr_data | input | 2 | Symbol written with `wr_stb` |
| deep | input | 1 | Depth select: 0 = 32 entries, 1 = 64 entries |
| los | input | 1 | Loss of signal; forces free-running nominal reads |
| rd_stb | output | 1 | Smoothed read strobe, one cycle per symbol |
| rd_data | output | 2 | Symbol read out with `rd_stb` |
| slip | output | 1 | One-cycle pulse on overflow or underflow recentring |

## Verification
The writer is driven at periods of 8, 7 and 6 reference cycles, and also stopped entirely. Each rate separates one regime from the others: a held nominal period with exact symbol latency, a reader that settles at the shortened period without slipping, hard overflow with slips, and a lengthened period ending in underflow. A depth switch right after reset checks that the latency moves from 16 to 32 reads. A loss-of-signal window with a fast writer confirms fixed 8-cycle reads of zero with no slip, and the release from it must give back a 16-read latency for the symbols written afterwards.

// File: rtl/es_jitter_atten.sv
module es_jitter_atten #(
  parameter int AW    = 6,
  parameter int DIV   = 8,
  parameter int GUARD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wr_data,
  input  logic       deep,
  input  logic       los,
  output logic       rd_stb,
  output logic [1:0] rd_data,
  output logic       slip
);
  localparam int FW   = AW + 1;
  localparam int CW   = $clog2(DIV + 2);
  localparam int MAXD = 1 << AW;
  localparam logic [CW-1:0] LIM_NOM  = CW'(DIV - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV - 2);
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV);

  logic [2:0]    stb_q;
  logic [1:0]    d1, d2;
  logic          deep_q, los_q;
  logic [AW-1:0] wp, rp;
  logic [FW-1:0] fill;
  logic [CW-1:0] cnt;
  logic [1:0]    mem [MAXD];

  wire [FW-1:0] depth      = deep ? FW'(MAXD) : FW'(MAXD / 2);
  wire [FW-1:0] half       = depth >> 1;
  wire [AW-1:0] mask       = AW'(depth - 1'b1);
  wire          near_full  = fill >= depth - FW'(GUARD);
  wire          near_empty = fill <= FW'(GUARD);
  wire          los_fall   = los_q & ~los;
  wire          dchg       = deep ^ deep_q;

  wire [CW-1:0] lim = los        ? LIM_NOM  :
                      near_full  ? LIM_FAST :
                      near_empty ? LIM_SLOW : LIM_NOM;

  wire fire     = (cnt >= lim) & ~los_fall;
  wire wr_en    = stb_q[1] & ~stb_q[2] & ~los;
  wire rd_en    = fire & ~los;
  wire ovf      = wr_en & ~rd_en & (fill == depth) & ~dchg;
  wire unf      = rd_en & ~wr_en & (fill == '0) & ~dchg;
  wire recentre = dchg | los_fall | ovf | unf;

  wire [AW-1:0] wp_nx = (wr_en ? wp + 1'b1 : wp) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= '0;
      d1      <= '0;
      d2      <= '0;
      deep_q  <= 1'b0;
      los_q   <= 1'b0;
      wp      <= '0;
      rp      <= AW'(MAXD / 4);
      fill    <= FW'(MAXD / 4);
      cnt     <= '0;
      rd_stb  <= 1'b0;
      rd_data <= '0;
      slip    <= 1'b0;
      for (int i = 0; i < MAXD; i++) mem[i] <= '0;
    end else begin
      stb_q  <= {stb_q[1:0], wr_stb};
      d1     <= wr_data;
      d2     <= d1;
      deep_q <= deep;
      los_q  <= los;
      cnt    <= (fire | los_fall) ? '0 : cnt + 1'b1;
      rd_stb <= fire;
      slip   <= ovf | unf;
      if (wr_en) mem[wp] <= d2;
      wp <= wp_nx;
      if (rd_en)     rd_data <= mem[rp];
      else if (fire) rd_data <= '0;
      if (recentre) begin
        rp   <= (wp_nx - half[AW-1:0]) & mask;
        fill <= half;
      end else begin
        if (rd_en) rp <= (rp + 1'b1) & mask;
        fill <= fill + FW'(wr_en) - FW'(rd_en);
      end
    end
  end
endmodule

// File: rtl/es_ja_checks.sv
module es_ja_checks #(
  parameter int DIV = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       los,
  input logic       rd_stb,
  input logic [1:0] rd_data,
  input logic       slip
);
  logic [7:0] gap_c;
  logic       los_d, lf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_c <= '0;
      los_d <= 1'b0;
      lf    <= 1'b0;
    end else begin
      gap_c <= rd_stb ? 8'd1 : ((gap_c == 8'hff) ? gap_c : gap_c + 8'd1);
      los_d <= los;
      lf    <= (los_d & ~los) | (lf & ~rd_stb);
    end
  end

  // R3, R4, R5: read period stays within one reference cycle of nominal
  a_r3_period_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (int'(gap_c) >= DIV - 1) && (lf || int'(gap_c) <= DIV + 1));

  a_r3_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  a_r7_slip_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !slip);

  a_r8_los_no_slip: assert property (@(posedge clk) disable iff (!rst_n)
    (los && $past(los)) |-> !slip);

  a_r8_los_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $past(los)) |-> rd_data == 2'b00);
endmodule

bind es_jitter_atten es_ja_checks #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .los(los),
  .rd_stb(rd_stb), .rd_data(rd_data), .slip(slip)
);

// File: tb/test_es_jitter_atten.sv
`timescale 1ns/1ps
module test_es_jitter_atten;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic       deep = 1'b0;
  logic       los = 1'b0;
  logic       rd_stb;
  logic [1:0] rd_data;
  logic       slip;

  es_jitter_atten i_es_jitter_atten (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .deep(deep), .los(los), .rd_stb(rd_stb), .rd_data(rd_data), .slip(slip)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int wper = 0, ph = 0, wcount = 0;
  int rcount = 0, lat = 16, cyc = 0, last = 0;
  bit have_last = 0, chk_data = 0, chk_zero = 0;
  int g7 = 0, g8 = 0, g9 = 0, gx = 0, slips = 0;
  string req = "R1";

  function automatic logic [1:0] pat(int k);
    return 2'((k ^ (k >> 2)) + (k >> 4) + 1);
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // writer
  initial forever begin
    @(negedge clk);
    if (wper == 0) wr_stb = 1'b0;
    else begin
      if (ph == 0) begin
        wr_stb  = 1'b1;
        wr_data = pat(wcount);
      end else if (ph == wper / 2) begin
        wr_stb = 1'b0;
        wcount++;
      end
      ph = (ph + 1 >= wper) ? 0 : ph + 1;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_n && rd_stb) begin
      if (chk_data && rcount >= lat)
        chk(rd_data == pat(rcount - lat), req, rd_data, pat(rcount - lat));
      else if (chk_zero)
        chk(rd_data == 2'b00, req, rd_data, 0);
      if (have_last) begin
        case (cyc - last)
          7: g7++;
          8: g8++;
          9: g9++;
          default: gx++;
        endcase
      end
      last = cyc;
      have_last = 1;
      rcount++;
    end
    if (rst_n && slip) slips++;
  end

  task automatic clear_stats();
    rcount = 0; have_last = 0;
    g7 = 0; g8 = 0; g9 = 0; gx = 0; slips = 0;
  endtask

  task automatic do_reset(bit d, bit l, int wp_, int lt, bit cd, bit cz, string r);
    rst_n = 1'b0; deep = d; los = l; wper = 0;
    chk_data = 0; chk_zero = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rd_stb == 0 && slip == 0 && rd_data == 0, "R3 reset", {rd_stb, slip, rd_data}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    clear_stats();
    wcount = 0; ph = 0;
    lat = lt; chk_data = cd; chk_zero = cz; req = r;
    wper = wp_;
  endtask

  initial begin
    // R1, R3: matched rate, depth 32
    do_reset(0, 0, 8, 16, 1, 1, "R1");
    repeat (1600) @(posedge clk); #1;
    chk(rcount > 100, "R1 reads", rcount, 100);
    chk(g8 > 0 && g7 == 0 && g9 == 0 && gx == 0, "R3 nominal period", g7 + g9 + gx, 0);
    chk(slips == 0, "R3 no slip", slips, 0);

    // R2, R6: switch to 64 entries right after reset
    do_reset(0, 0, 0, 32, 1, 1, "R2/R6 depth 64 latency");
    @(posedge clk); #1;
    deep = 1'b1;
    wper = 8;
    repeat (2000) @(posedge clk); #1;
    chk(rcount > 100, "R2 reads", rcount, 100);
    chk(g7 == 0 && g9 == 0 && gx == 0, "R6 period", g7 + g9 + gx, 0);
    chk(slips == 0, "R6 no slip", slips, 0);

    // R4: fast writer settles at shortened period
    do_reset(0, 0, 7, 16, 1, 1, "R4 data");
    repeat (3000) @(posedge clk); #1;
    chk(g7 > 0, "R4 shortened period seen", g7, 1);
    chk(g9 == 0 && gx == 0, "R4 no other period", g9 + gx, 0);
    chk(slips == 0, "R4 no slip", slips, 0);

    // R7: overflow
    do_reset(0, 0, 6, 16, 0, 0, "R7");
    repeat (3000) @(posedge clk); #1;
    chk(slips > 0, "R7 overflow slip", slips, 1);
    chk(g7 > 0 && g9 == 0 && gx == 0, "R4 period under overflow", g9 + gx, 0);

    // R5, R7: no writer, drain to underflow
    do_reset(0, 0, 0, 1000000, 0, 1, "R5 zero data");
    repeat (400) @(posedge clk); #1;
    chk(g9 > 0, "R5 lengthened period seen", g9, 1);
    chk(g7 == 0 && gx == 0, "R5 no other period", g7 + gx, 0);
    chk(slips > 0, "R7 underflow slip", slips, 1);

    // R8: loss of signal with a fast writer
    do_reset(0, 1, 6, 1000000, 0, 1, "R8 zero data");
    repeat (800) @(posedge clk); #1;
    chk(g8 > 50 && g7 == 0 && g9 == 0 && gx == 0, "R8 fixed period", g7 + g9 + gx, 0);
    chk(slips == 0, "R8 no slip", slips, 0);

    // R9: release and recentre
    wper = 0;
    repeat (12) @(posedge clk); #1;
    los = 1'b0;
    clear_stats();
    wcount = 0; ph = 0;
    lat = 16; chk_data = 1; chk_zero = 0; req = "R9 data";
    wper = 8;
    repeat (1600) @(posedge clk); #1;
    chk(rcount > 100, "R9 reads", rcount, 100);
    chk(g7 == 0 && g9 == 0 && gx == 0, "R9 period", g7 + g9 + gx, 0);
    chk(slips == 0, "R9 no slip", slips, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule